// File: doc/BRIEF.md
# Pass-Through Mailbox Ownership Controller

This block governs a 256-byte shared buffer. The buffer is organised as 64 blocks of four bytes each. Two agents use it to hand a chunk of data to each other, one direction at a time. The two agents are a contactless reader on the radio side and a host on the two-wire serial bus. A direction input names the producing side. While the buffer is filling, only that producer may touch it. When the producer writes the final byte (byte 3 of block 3Fh), ownership passes automatically to the consumer and a ready flag rises. When the consumer reads that same final byte, ownership returns to the producer and the flag falls.

Every buffer access from either side receives a one-cycle accept or refuse response. An access is refused when the side does not own the buffer. It is also refused when pass-through is not operational, which is the case unless the radio field, the supply and the buffer enable are all present. An active-low event output can be set to drop on each handover. The host releases it by writing a key value to a dedicated clear address. The buffer storage and the bus protocol framing sit outside this block.

Top module: `ptmbx_ctrl`

## Requirements
- R1: After reset, ready is 0, the owner is the producer named by the direction input, the event output is high (released), and no accept or refuse is indicated.
- R2: With ready at 0, direction 0 makes the serial host the producer (owner output 0), and direction 1 makes the radio side the producer (owner output 1). The owner output is 1 when the radio side owns the buffer.
- R3: An in-window access (write or read strobe) from the owning side, made while operational, is accepted (grant 1, refuse 0) on the next cycle. An in-window access from the other side is refused on the next cycle. Both sides are never granted in the same cycle.
- R4: If any one of field-present, supply-present or buffer-enable is 0, every in-window access is refused and no handover takes place.
- R5: The host window is block addresses 2000h to 203Fh, and the radio window is addresses 00h to 3Fh. A host access outside its window gives neither grant nor refuse. A radio access outside its window is refused.
- R6: An accepted producer write to byte 3 of the last block (host 203Fh or radio 3Fh) sets ready to 1 and moves ownership to the consumer on the next cycle. A write to any other byte leaves ready and the owner unchanged.
- R7: An accepted consumer read of byte 3 of the last block clears ready and returns ownership to the producer on the next cycle. Other reads leave ready unchanged, and so does a consumer write to that byte.
- R8: With event mode code 4'b0100, the event output goes low on the cycle after either handover. With any other code it stays high.
- R9: A host write of data 01h to address 10ACh releases the event output on the next cycle. Any other data has no effect. If a handover and a release fall in the same cycle, the handover wins and the output stays low.
- R10: A change of the direction input while ready is 1 changes neither the owner nor the consumer. The new direction takes effect once ready has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_field_ok | input | 1 | Radio field present |
| cfg_supply_ok | input | 1 | Host-side supply present |
| cfg_buf_en | input | 1 | Buffer enabled |
| cfg_dir | input | 1 | 0: host produces, radio consumes; 1: the reverse |
| cfg_evt_code | input | 4 | Event output mode; 4'b0100 = pulse on handover |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_addr | input | 16 | Host block address |
| h_byte | input | 2 | Byte within block, host side |
| h_wdata | input | 8 | Host write data (compared only for the event release) |
| r_wr | input | 1 | Radio write strobe, one cycle |
| r_rd | input | 1 | Radio read strobe, one cycle |
| r_addr | input | 8 | Radio buffer block address |
| r_byte | input | 2 | Byte within block, radio side |
| owner_rf | output | 1 | 1 when the radio side owns the buffer |
| data_ready | output | 1 | Buffer full and waiting for the consumer |
| h_grant | output | 1 | Host access accepted |
| h_nak | output | 1 | Host access refused |
| r_grant | output | 1 | Radio access accepted |
| r_nak | output | 1 | Radio access refused |
| evt_n | output | 1 | Active-low event output |

## Verification
Grant, refuse, ready and the event output are all registered. A strobe presented at one clock edge is therefore answered after exactly that edge. The bench drives each strobe on a falling edge and compares results at the next falling edge, once the single register stage has updated. The owner output follows the direction input combinationally while ready is 0. Direction changes are therefore checked one falling edge after they are applied. In that same cycle, while ready is 1, the owner is checked to stay unmoved.

// File: rtl/ptmbx_pkg.sv
package ptmbx_pkg;
  localparam int unsigned BLK_COUNT     = 64;
  localparam int unsigned BYTES_PER_BLK = 4;
  localparam int unsigned HOST_AW       = 16;
  localparam int unsigned RF_AW         = 8;
  localparam int unsigned EVT_CODE_W    = 4;
  localparam logic [3:0]  EVT_ON_TERM   = 4'b0100;
  localparam logic [15:0] HOST_BASE     = 16'h2000;
  localparam logic [15:0] EVT_CLR_ADDR  = 16'h10AC;
  localparam logic [7:0]  EVT_CLR_KEY   = 8'h01;

  // address lies in [base, base+count)
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned count);
    return (addr >= base) && (addr < base + count);
  endfunction

  // final byte of the final block: the terminator
  function automatic logic is_terminator(input int unsigned offs,
                                         input int unsigned byte_idx,
                                         input int unsigned count,
                                         input int unsigned bpb);
    return (offs == count - 1) && (byte_idx == bpb - 1);
  endfunction
endpackage

// File: rtl/ptmbx_addr_win.sv
module ptmbx_addr_win
  import ptmbx_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned BW    = 2,
  parameter int unsigned BASE  = 0,
  parameter int unsigned BLKS  = 64,
  parameter int unsigned BPB   = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] byte_sel,
  output logic          hit,
  output logic          term
);
  localparam int unsigned PADW = 32 - AW;
  localparam int unsigned PADB = 32 - BW;

  logic [31:0] addr_w;
  logic [31:0] byte_w;
  logic [31:0] offs;

  assign addr_w = {{PADW{1'b0}}, addr};
  assign byte_w = {{PADB{1'b0}}, byte_sel};
  assign offs   = addr_w - BASE;
  assign hit    = in_window(addr_w, BASE, BLKS);
  assign term   = hit && is_terminator(offs, byte_w, BLKS, BPB);
endmodule

// File: rtl/ptmbx_handshake.sv
module ptmbx_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cfg_dir,
  input  logic h_wr,
  input  logic h_rd,
  input  logic h_hit,
  input  logic h_term,
  input  logic r_wr,
  input  logic r_rd,
  input  logic r_hit,
  input  logic r_term,
  output logic owner_rf,
  output logic data_ready,
  output logic h_grant,
  output logic h_nak,
  output logic r_grant,
  output logic r_nak,
  output logic fill_done,
  output logic drain_done
);
  logic rd_rf_q;      // consumer side latched at handover
  logic h_acc, r_acc;
  logic h_ok, r_ok;
  logic h_wop, h_rop, r_wop, r_rop;

  // a write strobe takes precedence over a read strobe on the same side
  assign h_acc = h_wr | h_rd;
  assign r_acc = r_wr | r_rd;
  assign h_wop = h_wr;
  assign h_rop = h_rd & ~h_wr;
  assign r_wop = r_wr;
  assign r_rop = r_rd & ~r_wr;

  assign owner_rf = data_ready ? rd_rf_q : cfg_dir;

  assign h_ok = active & ~owner_rf & h_hit;
  assign r_ok = active &  owner_rf & r_hit;

  assign fill_done  = ~data_ready & ((h_ok & h_wop & h_term) | (r_ok & r_wop & r_term));
  assign drain_done =  data_ready & ((h_ok & h_rop & h_term) | (r_ok & r_rop & r_term));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready <= 1'b0;
      rd_rf_q    <= 1'b0;
      h_grant    <= 1'b0;
      h_nak      <= 1'b0;
      r_grant    <= 1'b0;
      r_nak      <= 1'b0;
    end else begin
      if (fill_done) begin
        data_ready <= 1'b1;
        rd_rf_q    <= ~cfg_dir;
      end else if (drain_done) begin
        data_ready <= 1'b0;
      end
      h_grant <= h_acc & h_ok;
      h_nak   <= h_acc & h_hit & ~h_ok;
      r_grant <= r_acc & r_ok;
      r_nak   <= r_acc & ~r_ok;
    end
  end
endmodule

// File: rtl/ptmbx_event.sv
module ptmbx_event
  import ptmbx_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] evt_code,
  input  logic          fill_done,
  input  logic          drain_done,
  input  logic          evt_clr,
  output logic          evt_n
);
  logic evt_set;

  assign evt_set = (evt_code == CW'(EVT_ON_TERM)) && (fill_done || drain_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_n <= 1'b1;
    else if (evt_set)  evt_n <= 1'b0;
    else if (evt_clr)  evt_n <= 1'b1;
  end
endmodule

// File: rtl/ptmbx_ctrl.sv
module ptmbx_ctrl
  import ptmbx_pkg::*;
#(
  parameter int unsigned NBLK     = BLK_COUNT,
  parameter int unsigned BPB      = BYTES_PER_BLK,
  parameter int unsigned HAW      = HOST_AW,
  parameter int unsigned RAW      = RF_AW,
  parameter int unsigned ECW      = EVT_CODE_W,
  parameter logic [15:0] HBASE    = HOST_BASE,
  parameter logic [15:0] CLR_ADDR = EVT_CLR_ADDR,
  parameter logic [7:0]  CLR_KEY  = EVT_CLR_KEY
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_field_ok,
  input  logic                   cfg_supply_ok,
  input  logic                   cfg_buf_en,
  input  logic                   cfg_dir,
  input  logic [ECW-1:0]         cfg_evt_code,
  input  logic                   h_wr,
  input  logic                   h_rd,
  input  logic [HAW-1:0]         h_addr,
  input  logic [$clog2(BPB)-1:0] h_byte,
  input  logic [7:0]             h_wdata,
  input  logic                   r_wr,
  input  logic                   r_rd,
  input  logic [RAW-1:0]         r_addr,
  input  logic [$clog2(BPB)-1:0] r_byte,
  output logic                   owner_rf,
  output logic                   data_ready,
  output logic                   h_grant,
  output logic                   h_nak,
  output logic                   r_grant,
  output logic                   r_nak,
  output logic                   evt_n
);
  localparam int unsigned BW = $clog2(BPB);

  // named internal events, visible to the bound checker
  logic active;
  logic h_hit, h_term, r_hit, r_term;
  logic fill_done, drain_done;
  logic evt_clr;

  assign active  = cfg_field_ok & cfg_supply_ok & cfg_buf_en;
  assign evt_clr = h_wr && (h_addr == HAW'(CLR_ADDR)) && (h_wdata == CLR_KEY);

  ptmbx_addr_win #(.AW(HAW), .BW(BW), .BASE(32'(HBASE)), .BLKS(NBLK), .BPB(BPB)) u_hwin (
    .addr(h_addr), .byte_sel(h_byte), .hit(h_hit), .term(h_term)
  );

  ptmbx_addr_win #(.AW(RAW), .BW(BW), .BASE(0), .BLKS(NBLK), .BPB(BPB)) u_rwin (
    .addr(r_addr), .byte_sel(r_byte), .hit(r_hit), .term(r_term)
  );

  ptmbx_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .active(active), .cfg_dir(cfg_dir),
    .h_wr(h_wr), .h_rd(h_rd), .h_hit(h_hit), .h_term(h_term),
    .r_wr(r_wr), .r_rd(r_rd), .r_hit(r_hit), .r_term(r_term),
    .owner_rf(owner_rf), .data_ready(data_ready),
    .h_grant(h_grant), .h_nak(h_nak), .r_grant(r_grant), .r_nak(r_nak),
    .fill_done(fill_done), .drain_done(drain_done)
  );

  ptmbx_event #(.CW(ECW)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_code(cfg_evt_code),
    .fill_done(fill_done), .drain_done(drain_done),
    .evt_clr(evt_clr), .evt_n(evt_n)
  );
endmodule

// File: rtl/ptmbx_ctrl_chk.sv
module ptmbx_ctrl_chk
  import ptmbx_pkg::*;
#(
  parameter int unsigned ECW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           active,
  input logic           h_wr,
  input logic           h_rd,
  input logic           h_hit,
  input logic [ECW-1:0] cfg_evt_code,
  input logic           fill_done,
  input logic           drain_done,
  input logic           evt_clr,
  input logic           owner_rf,
  input logic           data_ready,
  input logic           h_grant,
  input logic           h_nak,
  input logic           r_grant,
  input logic           evt_n
);
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_grant && r_grant));

  assert_idle_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (h_wr || h_rd) && h_hit) |=> (h_nak && !h_grant));

  assert_fill_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (data_ready && (owner_rf != $past(owner_rf))));

  assert_drain_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !data_ready);

  assert_evt_on_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_evt_code == ECW'(EVT_ON_TERM)) && (fill_done || drain_done)) |=> !evt_n);

  assert_evt_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_n) |-> $past(evt_clr));

  assert_owner_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && $past(data_ready)) |-> (owner_rf == $past(owner_rf)));
endmodule

bind ptmbx_ctrl ptmbx_ctrl_chk #(.ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .h_wr(h_wr), .h_rd(h_rd),
  .h_hit(h_hit), .cfg_evt_code(cfg_evt_code), .fill_done(fill_done),
  .drain_done(drain_done), .evt_clr(evt_clr), .owner_rf(owner_rf),
  .data_ready(data_ready), .h_grant(h_grant), .h_nak(h_nak),
  .r_grant(r_grant), .evt_n(evt_n)
);

// File: tb/ptmbx_ctrl_test.sv
module ptmbx_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_field_ok = 1'b1, cfg_supply_ok = 1'b1, cfg_buf_en = 1'b1;
  logic       cfg_dir = 1'b0;
  logic [3:0] cfg_evt_code = 4'b0100;
  logic       h_wr = 1'b0, h_rd = 1'b0;
  logic [15:0] h_addr = '0;
  logic [1:0] h_byte = '0;
  logic [7:0] h_wdata = '0;
  logic       r_wr = 1'b0, r_rd = 1'b0;
  logic [7:0] r_addr = '0;
  logic [1:0] r_byte = '0;
  logic owner_rf, data_ready, h_grant, h_nak, r_grant, r_nak, evt_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptmbx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_field_ok(cfg_field_ok), .cfg_supply_ok(cfg_supply_ok),
    .cfg_buf_en(cfg_buf_en), .cfg_dir(cfg_dir), .cfg_evt_code(cfg_evt_code),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_byte(h_byte), .h_wdata(h_wdata),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_byte(r_byte),
    .owner_rf(owner_rf), .data_ready(data_ready), .h_grant(h_grant), .h_nak(h_nak),
    .r_grant(r_grant), .r_nak(r_nak), .evt_n(evt_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on a falling edge; results are registered and sampled at the next one
  task automatic host_op(input logic wr, input logic [15:0] a, input logic [1:0] b,
                         input logic [7:0] d);
    h_wr = wr; h_rd = ~wr; h_addr = a; h_byte = b; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b0;
  endtask

  task automatic rf_op(input logic wr, input logic [7:0] a, input logic [1:0] b);
    r_wr = wr; r_rd = ~wr; r_addr = a; r_byte = b;
    @(negedge clk);
    r_wr = 1'b0; r_rd = 1'b0;
  endtask

  // full sweep of all 64 blocks x 4 bytes from one side
  task automatic sweep(input bit host_side, input bit wr);
    for (int blk = 0; blk < 64; blk++) begin
      for (int b = 0; b < 4; b++) begin
        bit last = (blk == 63) && (b == 3);
        int exp_dr = wr ? int'(last) : int'(!last);
        if (host_side) begin
          host_op(wr, 16'h2000 + 16'(blk), 2'(b), 8'(blk * 4 + b));
          chk("R3 host owner grant", int'(h_grant), 1);
        end else begin
          rf_op(wr, 8'(blk), 2'(b));
          chk("R3 rf owner grant", int'(r_grant), 1);
        end
        chk(wr ? "R6 ready during fill" : "R7 ready during drain", int'(data_ready), exp_dr);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(data_ready), 0);
    chk("R1 owner", int'(owner_rf), 0);
    chk("R1 evt_n", int'(evt_n), 1);
    chk("R1 grants", int'(h_grant | r_grant | h_nak | r_nak), 0);

    // dir 0: host produces. Non-owner radio refused
    rf_op(1'b1, 8'h00, 2'd0);
    chk("R3 rf non-owner nak", int'(r_nak), 1);
    chk("R3 rf non-owner grant", int'(r_grant), 0);
    sweep(1'b1, 1'b1);
    chk("R6 owner to rf", int'(owner_rf), 1);
    chk("R8 evt after fill", int'(evt_n), 0);
    host_op(1'b1, 16'h2000, 2'd0, 8'h00);
    chk("R3 host non-owner nak", int'(h_nak), 1);
    // consumer write to terminator does not drain
    rf_op(1'b1, 8'h3F, 2'd3);
    chk("R7 consumer write no drain", int'(data_ready), 1);
    sweep(1'b0, 1'b0);
    chk("R7 owner back to host", int'(owner_rf), 0);
    chk("R8 evt low", int'(evt_n), 0);
    host_op(1'b1, 16'h10AC, 2'd0, 8'h02);
    chk("R9 wrong key ignored", int'(evt_n), 0);
    host_op(1'b1, 16'h10AC, 2'd0, 8'h01);
    chk("R9 release", int'(evt_n), 1);

    // R2 direction 1: radio produces
    cfg_dir = 1'b1;
    @(negedge clk);
    chk("R2 owner follows dir", int'(owner_rf), 1);
    rf_op(1'b1, 8'h3F, 2'd2);
    chk("R6 non-terminator write", int'(data_ready), 0);
    rf_op(1'b1, 8'h3F, 2'd3);
    chk("R6 rf fill handover", int'(data_ready), 1);
    chk("R6 owner to host", int'(owner_rf), 0);
    // R10 direction change while ready ignored
    cfg_dir = 1'b0;
    @(negedge clk);
    chk("R10 owner held", int'(owner_rf), 0);
    chk("R10 ready held", int'(data_ready), 1);
    host_op(1'b0, 16'h2000, 2'd0, 8'h00);
    chk("R7 non-terminator read", int'(data_ready), 1);
    host_op(1'b0, 16'h203F, 2'd3, 8'h00);
    chk("R7 host drain", int'(data_ready), 0);
    chk("R10 new dir after drain", int'(owner_rf), 0);
    host_op(1'b1, 16'h10AC, 2'd0, 8'h01);

    // R5 windows (host owns, dir 0)
    host_op(1'b1, 16'h2040, 2'd0, 8'h00);
    chk("R5 host above window", int'(h_grant | h_nak), 0);
    host_op(1'b1, 16'h1FFF, 2'd0, 8'h00);
    chk("R5 host below window", int'(h_grant | h_nak), 0);
    host_op(1'b0, 16'h203F, 2'd2, 8'h00);
    chk("R5 host in window", int'(h_grant), 1);
    rf_op(1'b0, 8'h40, 2'd0);
    chk("R5 rf out of window nak", int'(r_nak), 1);

    // R4 each operational condition dropped in turn
    for (int k = 0; k < 3; k++) begin
      cfg_field_ok = (k != 0); cfg_supply_ok = (k != 1); cfg_buf_en = (k != 2);
      host_op(1'b1, 16'h203F, 2'd3, 8'h00);
      chk("R4 inactive nak", int'(h_nak), 1);
      chk("R4 inactive grant", int'(h_grant), 0);
      chk("R4 no handover", int'(data_ready), 0);
    end
    cfg_field_ok = 1'b1; cfg_supply_ok = 1'b1; cfg_buf_en = 1'b1;

    // R8 other code: no event
    cfg_evt_code = 4'b0000;
    host_op(1'b1, 16'h203F, 2'd3, 8'h00);
    chk("R8 code0 fill", int'(data_ready), 1);
    chk("R8 code0 evt high", int'(evt_n), 1);
    rf_op(1'b0, 8'h3F, 2'd3);
    chk("R8 code0 drain", int'(data_ready), 0);
    chk("R8 code0 evt still high", int'(evt_n), 1);
    cfg_evt_code = 4'b0100;

    // R9 handover beats release in the same cycle
    host_op(1'b1, 16'h203F, 2'd3, 8'h00);
    chk("R8 evt after host fill", int'(evt_n), 0);
    host_op(1'b1, 16'h10AC, 2'd0, 8'h01);
    chk("R9 released", int'(evt_n), 1);
    h_wr = 1'b1; h_addr = 16'h10AC; h_wdata = 8'h01;
    r_rd = 1'b1; r_addr = 8'h3F; r_byte = 2'd3;
    @(negedge clk);
    h_wr = 1'b0; r_rd = 1'b0;
    chk("R9 set wins", int'(evt_n), 0);
    chk("R7 drain with clear", int'(data_ready), 0);
    host_op(1'b1, 16'h10AC, 2'd0, 8'h01);
    chk("R9 final release", int'(evt_n), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule